// File: doc/BRIEF.md
# Memory Protection Region CSR File

This block keeps the control and status registers that describe a set of memory protection regions for a small 32-bit core. Each region owns one 8-bit configuration byte and one 32-bit address register. Four configuration bytes are packed into each 32-bit configuration CSR. The number of regions is a parameter. A second parameter turns protection off, and every slot then reads as zero.

The core reaches the registers through a simple CSR port. It drives a strobe, a 2-bit operation code, a 12-bit CSR number and 32 bits of write data. The block answers in the same cycle with the old register value and an illegal-access flag. The port has no valid/ready back-pressure: every strobed access is accepted in the cycle it is presented. Any update lands on the next rising clock edge.

The block applies the legality rules on every update:
- Per-region locking.
- Write protection of an address register while the region above it is in top-of-range mode.
- Masking of bits that are never stored.
- Clean-up of the reserved write-without-read permission pair.

All configuration bytes and address registers are also driven out in parallel, for a separate region-matching unit.

Top module: `pmp_csr_file`

## Requirements
- R1: Operation code 0 reads with no change. Code 1 replaces the register with the write data. Code 2 ORs the write data in. Code 3 clears the bits that are set in the write data.
- R2: While `csr_req` is high, `csr_rdata` combinationally shows the addressed register's value from before any update. While `csr_req` is low, `csr_rdata` and `csr_illegal` are zero.
- R3: Configuration CSR k sits at 0x3A0+k. Region n's byte is at bits [8*(n%4)+7 : 8*(n%4)] of CSR 0x3A0+n/4. Address register n sits at 0x3B0+n. The outputs place region n at `region_cfg[8n+7:8n]` and `region_addr[32n+31:32n]`.
- R4: Bit 7 of a configuration byte is the lock bit. While it is set, no operation changes any bit of that byte.
- R5: Each configuration byte stores only the bits of mask 0x9F. Bits 6:5 always read zero.
- R6: If an update leaves bits 1:0 of a byte at 2'b10 (write without read), both bits are stored as zero.
- R7: Address register n ignores all operations while region n's lock bit is set.
- R8: Address register n also ignores operations while region n+1's mode field, bits 4:3, equals 2'b01 (top-of-range). This condition never applies to the last region.
- R9: The following slots read zero, ignore writes, and do not raise `csr_illegal`:
  - configuration bytes and CSRs beyond the region count;
  - address registers beyond the region count;
  - every slot when protection is disabled.
- R10: A strobed access outside 0x3A0–0x3A3 and 0x3B0–0x3BF raises `csr_illegal`, returns zero and changes no register.
- R11: With `rst_n` low, every configuration byte and address register is zero.
- R12: Registers change only on a rising clock edge at which `csr_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | Access strobe |
| csr_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | 32 | Write/set/clear operand |
| csr_rdata | output | 32 | Pre-update value of the addressed register |
| csr_illegal | output | 1 | Strobed access to an unknown CSR number |
| region_cfg | output | 8*NUM_REGIONS | All configuration bytes, region n at [8n+7:8n] |
| region_addr | output | 32*NUM_REGIONS | All address registers, region n at [32n+31:32n] |

## Verification
The bench drives the four operation codes on one address register. This shows that write, set, clear and read are decoded apart, and that the pre-update value is returned.

Configuration bytes carrying every reserved pattern at once are written in a single access. Each byte lane is checked on its own, which separates the 0x9F masking from the write-without-read clean-up, and a lane-order fault shows up as a misplaced byte.

Lock, top-of-range and last-region cases compare an address register's value before and after the blocked write. Accesses to unimplemented, out-of-range and unstrobed addresses confirm that the illegal flag and the implemented-slot decode are distinct conditions.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [11:0] CFG_BASE  = 12'h3A0;
  localparam logic [11:0] ADDR_BASE = 12'h3B0;
  localparam logic [7:0]  CFG_KEEP  = 8'h9F;
  localparam logic [1:0]  MODE_TOR  = 2'b01;
  localparam int          MAX_REGIONS = 16;

  function automatic logic [31:0] apply_op(csr_op_e op, logic [31:0] cur, logic [31:0] arg);
    logic [31:0] res;
    case (op)
      OP_WRITE: res = arg;
      OP_SET:   res = cur | arg;
      OP_CLEAR: res = cur & ~arg;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode
  import pmp_csr_pkg::*;
#(
  parameter bit PROT_EN     = 1'b1,
  parameter int NUM_REGIONS = 4
) (
  input  logic [11:0] addr,
  output logic        hit_cfg,
  output logic        hit_addr,
  output logic        impl,
  output logic [1:0]  cfg_sel,
  output logic [3:0]  addr_sel
);
  localparam int NUM_CFG = (NUM_REGIONS + 3) / 4;
  localparam logic [2:0] NC3 = 3'(NUM_CFG);
  localparam logic [4:0] NR5 = 5'(NUM_REGIONS);

  always_comb begin
    hit_cfg  = (addr[11:2] == CFG_BASE[11:2]);
    hit_addr = (addr[11:4] == ADDR_BASE[11:4]);
    cfg_sel  = addr[1:0];
    addr_sel = addr[3:0];
    impl     = 1'b0;
    if (PROT_EN) begin
      if (hit_cfg)       impl = ({1'b0, cfg_sel} < NC3);
      else if (hit_addr) impl = ({1'b0, addr_sel} < NR5);
    end
  end
endmodule

// File: rtl/pmp_cfg_byte.sv
module pmp_cfg_byte
  import pmp_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  csr_op_e    op,
  input  logic [7:0] wbyte,
  output logic [7:0] cfg_q
);
  logic [31:0] upd;
  logic [7:0]  nxt;

  always_comb begin
    upd = apply_op(op, {24'b0, cfg_q}, {24'b0, wbyte});
    nxt = upd[7:0] & CFG_KEEP;
    if (nxt[1:0] == 2'b10) nxt[1:0] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg_q <= '0;
    else if (we && !cfg_q[7])  cfg_q <= nxt;
  end

  assert_lock_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7] |=> $stable(cfg_q));
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[6:5] == 2'b00);
  assert_no_wonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[1:0] != 2'b10);
endmodule

// File: rtl/pmp_addr_reg.sv
module pmp_addr_reg
  import pmp_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        lock,
  input  csr_op_e     op,
  input  logic [31:0] wdata,
  output logic [31:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addr_q <= '0;
    else if (we && !lock) addr_q <= apply_op(op, addr_q, wdata);
  end

  // R7 and R8: either lock source freezes the register
  assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(addr_q));
  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(addr_q));
endmodule

// File: rtl/pmp_csr_file.sv
module pmp_csr_file
  import pmp_csr_pkg::*;
#(
  parameter bit PROT_EN     = 1'b1,
  parameter int NUM_REGIONS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csr_req,
  input  logic [1:0]                csr_op,
  input  logic [11:0]               csr_addr,
  input  logic [31:0]               csr_wdata,
  output logic [31:0]               csr_rdata,
  output logic                      csr_illegal,
  output logic [8*NUM_REGIONS-1:0]  region_cfg,
  output logic [32*NUM_REGIONS-1:0] region_addr
);
  localparam int LAST = NUM_REGIONS - 1;

  csr_op_e     op;
  logic        hit_cfg, hit_addr, impl;
  logic [1:0]  cfg_sel;
  logic [3:0]  addr_sel;
  logic        upd_ok;
  logic [7:0]  cfg_pad  [MAX_REGIONS];
  logic [31:0] addr_pad [MAX_REGIONS];

  assign op = csr_op_e'(csr_op);

  pmp_csr_decode #(.PROT_EN(PROT_EN), .NUM_REGIONS(NUM_REGIONS)) u_dec (
    .addr(csr_addr), .hit_cfg(hit_cfg), .hit_addr(hit_addr), .impl(impl),
    .cfg_sel(cfg_sel), .addr_sel(addr_sel)
  );

  assign upd_ok = csr_req && impl && (op != OP_READ);

  for (genvar r = 0; r < MAX_REGIONS; r++) begin : g_reg
    if (r < NUM_REGIONS) begin : g_on
      logic [7:0]  cfg_q;
      logic [31:0] addr_q;
      logic        next_tor;

      if (r < LAST) begin : g_nxt
        assign next_tor = (g_reg[r+1].g_on.cfg_q[4:3] == MODE_TOR);
      end else begin : g_last
        assign next_tor = 1'b0;
      end

      pmp_cfg_byte u_cfg (
        .clk(clk), .rst_n(rst_n),
        .we(upd_ok && hit_cfg && (cfg_sel == 2'(r / 4))),
        .op(op), .wbyte(csr_wdata[8*(r%4) +: 8]), .cfg_q(cfg_q)
      );

      pmp_addr_reg u_addr (
        .clk(clk), .rst_n(rst_n),
        .we(upd_ok && hit_addr && (addr_sel == 4'(r))),
        .lock(cfg_q[7] || next_tor),
        .op(op), .wdata(csr_wdata), .addr_q(addr_q)
      );

      assign cfg_pad[r]  = cfg_q;
      assign addr_pad[r] = addr_q;
      assign region_cfg[8*r +: 8]   = cfg_q;
      assign region_addr[32*r +: 32] = addr_q;
    end else begin : g_off
      assign cfg_pad[r]  = '0;
      assign addr_pad[r] = '0;
    end
  end

  always_comb begin
    csr_rdata   = '0;
    csr_illegal = csr_req && !hit_cfg && !hit_addr;
    if (csr_req && impl) begin
      if (hit_cfg)
        csr_rdata = {cfg_pad[{cfg_sel, 2'd3}], cfg_pad[{cfg_sel, 2'd2}],
                     cfg_pad[{cfg_sel, 2'd1}], cfg_pad[{cfg_sel, 2'd0}]};
      else
        csr_rdata = addr_pad[addr_sel];
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_req |-> (csr_rdata == 32'd0 && !csr_illegal));
  assert_far_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_addr[11:8] != 4'h3) |-> (csr_illegal && csr_rdata == 32'd0));
  assert_illegal_no_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |=> ($stable(region_cfg) && $stable(region_addr)));
  assert_top_slot_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_addr == 12'h3BF && NUM_REGIONS < 16) |-> (csr_rdata == 32'd0 && !csr_illegal));
endmodule

// File: tb/tb_pmp_csr_file.sv
module tb_pmp_csr_file;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_req = 1'b0;
  logic [1:0]  csr_op = 2'd0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic [31:0] region_cfg;
  logic [127:0] region_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_csr_file #(.PROT_EN(1'b1), .NUM_REGIONS(4)) dut (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .region_cfg(region_cfg), .region_addr(region_addr)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic ill);
    @(negedge clk);
    csr_req = 1'b1; csr_op = op; csr_addr = a; csr_wdata = wd;
    #1; rd = csr_rdata; ill = csr_illegal;
    @(posedge clk); #1;
    csr_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic il;
    do_reset();
    chk("R11 cfg out", region_cfg, 0);
    chk("R11 addr out", region_addr, 0);
    acc(2'd0, 12'h3A0, 0, rd, il);
    chk("R11 cfg read", rd, 0);
  endtask

  task automatic t_ops();
    logic [31:0] rd; logic il;
    do_reset();
    acc(2'd1, 12'h3B0, 32'h12345678, rd, il);
    chk("R2 old value on write", rd, 0);
    acc(2'd0, 12'h3B0, 0, rd, il);
    chk("R1 write", rd, 32'h12345678);
    acc(2'd2, 12'h3B0, 32'h0000000F, rd, il);
    chk("R2 old value on set", rd, 32'h12345678);
    acc(2'd3, 12'h3B0, 32'h000000F0, rd, il);
    chk("R1 set result", rd, 32'h1234567F);
    acc(2'd0, 12'h3B0, 32'hFFFFFFFF, rd, il);
    chk("R1 clear result", rd, 32'h1234560F);
    acc(2'd0, 12'h3B0, 0, rd, il);
    chk("R1 read no change", rd, 32'h1234560F);
    chk("R3 addr0 export", region_addr[31:0], 32'h1234560F);
    acc(2'd1, 12'h3B3, 32'hCAFE0003, rd, il);
    chk("R3 addr3 export", region_addr[127:96], 32'hCAFE0003);
  endtask

  task automatic t_strobe();
    logic [31:0] rd; logic il;
    do_reset();
    @(negedge clk);
    csr_req = 1'b0; csr_op = 2'd1; csr_addr = 12'h3B1; csr_wdata = 32'hDEADBEEF;
    #1;
    chk("R2 rdata zero without strobe", csr_rdata, 0);
    @(posedge clk); #1;
    chk("R12 no update without strobe", region_addr[63:32], 0);
    acc(2'd0, 12'h3B1, 0, rd, il);
    chk("R12 read back", rd, 0);
  endtask

  task automatic t_mask();
    logic [31:0] rd; logic il;
    do_reset();
    acc(2'd1, 12'h3A0, 32'h050E7B62, rd, il);
    acc(2'd0, 12'h3A0, 0, rd, il);
    chk("R5 R6 cfg word", rd, 32'h050C1B00);
    chk("R6 byte0 wonly cleared", region_cfg[7:0], 8'h00);
    chk("R5 byte1 masked", region_cfg[15:8], 8'h1B);
    chk("R3 R6 byte2 lane", region_cfg[23:16], 8'h0C);
    chk("R3 byte3 lane", region_cfg[31:24], 8'h05);
  endtask

  task automatic t_tor();
    logic [31:0] rd; logic il;
    do_reset();
    acc(2'd1, 12'h3B0, 32'h11, rd, il);
    acc(2'd1, 12'h3A0, 32'h00000800, rd, il);
    acc(2'd1, 12'h3B0, 32'h22, rd, il);
    acc(2'd0, 12'h3B0, 0, rd, il);
    chk("R8 addr0 locked by region1 top-of-range", rd, 32'h11);
    acc(2'd1, 12'h3B1, 32'h33, rd, il);
    acc(2'd0, 12'h3B1, 0, rd, il);
    chk("R8 addr1 still writable", rd, 32'h33);
    acc(2'd2, 12'h3A0, 32'h08000000, rd, il);
    acc(2'd1, 12'h3B2, 32'h99, rd, il);
    chk("R8 addr2 locked by region3 top-of-range", region_addr[95:64], 0);
    acc(2'd1, 12'h3B3, 32'h44, rd, il);
    chk("R8 last region never next-locked", region_addr[127:96], 32'h44);
  endtask

  task automatic t_lock();
    logic [31:0] rd; logic il;
    do_reset();
    acc(2'd1, 12'h3B1, 32'h55, rd, il);
    acc(2'd1, 12'h3A0, 32'h00008100, rd, il);
    acc(2'd1, 12'h3A0, 32'hFFFFFFFF, rd, il);
    acc(2'd0, 12'h3A0, 0, rd, il);
    chk("R4 locked byte frozen on write", rd, 32'h9F9F819F);
    acc(2'd3, 12'h3A0, 32'hFFFFFFFF, rd, il);
    acc(2'd0, 12'h3A0, 0, rd, il);
    chk("R4 locked bytes frozen on clear", rd, 32'h9F9F819F);
    acc(2'd1, 12'h3B1, 32'h66, rd, il);
    acc(2'd0, 12'h3B1, 0, rd, il);
    chk("R7 addr1 locked by own lock", rd, 32'h55);
  endtask

  task automatic t_unimpl();
    logic [31:0] rd; logic il;
    do_reset();
    acc(2'd1, 12'h3A1, 32'hFFFFFFFF, rd, il);
    chk("R9 cfg1 no illegal", il, 0);
    acc(2'd0, 12'h3A1, 0, rd, il);
    chk("R9 cfg1 reads zero", rd, 0);
    acc(2'd1, 12'h3B5, 32'h1, rd, il);
    acc(2'd0, 12'h3B5, 0, rd, il);
    chk("R9 addr5 reads zero", rd, 0);
    chk("R9 addr5 no illegal", il, 0);
    chk("R9 no side effect", {region_cfg, region_addr[95:0]}, 0);
  endtask

  task automatic t_illegal();
    logic [31:0] rd; logic il;
    do_reset();
    acc(2'd1, 12'h300, 32'hFFFFFFFF, rd, il);
    chk("R10 0x300 illegal", il, 1);
    chk("R10 0x300 reads zero", rd, 0);
    acc(2'd1, 12'h3A4, 32'hFFFFFFFF, rd, il);
    chk("R10 0x3A4 illegal", il, 1);
    acc(2'd1, 12'h3C0, 32'hFFFFFFFF, rd, il);
    chk("R10 0x3C0 illegal", il, 1);
    chk("R10 no update", {region_cfg, region_addr}, 0);
    acc(2'd0, 12'h3BF, 0, rd, il);
    chk("R10 0x3BF legal", il, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ops();
    t_strobe();
    t_mask();
    t_tor();
    t_lock();
    t_unimpl();
    t_illegal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule